// File: doc/BRIEF.md
# Prescaled Modulus Timer Counter

This block is a 16-bit up-counter fed from the bus clock through a power-of-two prescaler. The prescaler ratio runs from 1 to 128 and is chosen by a 3-bit field in a control byte. Two further control bits enable the overflow interrupt and a modulus mode. In modulus mode the counter is cleared whenever it reaches the channel-7 compare value. The block drives the live count, a sticky overflow flag that software clears by writing a 1, an interrupt request, and a one-cycle compare-hit pulse.

A change of the prescale ratio does not take effect at once. It waits until the free-running prescaler chain has returned to all zeros, so no shortened or stretched tick can occur. A small two-state machine inside the prescaler handles this:

- `PS_STEADY`: the active ratio equals the programmed one. The transition *request* moves it to `PS_PENDING` when the programmed ratio differs from the active one.
- `PS_PENDING`: the active ratio is held. The transition *commit* loads the programmed ratio and returns to `PS_STEADY` at the end of a cycle in which every prescaler stage reads zero.

Top module: `ptmr_top`

## Requirements
- R1: After reset the count is 0x0000, the control byte reads 0x00, and the overflow flag, interrupt request and compare-hit pulse are all 0.
- R2: The control byte uses these bit positions: bit 7 is the overflow-interrupt enable, bit 3 is the modulus enable, and bits 2:0 are the prescale select. Bits 6:4 always read 0, and writes to them are ignored. Writing 0xFF reads back as 0x8F.
- R3: With prescale select p, the counter advances exactly once per 2^p bus clocks, for p = 0 (÷1) up to p = 7 (÷128).
- R4: A newly written prescale select is used only from the cycle after every prescaler stage has read zero. Until then the counter keeps the previous ratio.
- R5: With the modulus enable at 0, the counter runs freely and rolls from 0xFFFF to 0x0000.
- R6: With the modulus enable at 1 and a nonzero compare value C, the counter reads 0 on the prescaled tick after it reads C. The cycle therefore spans (C+1)·2^p bus clocks, which is C+1 bus clocks at ÷1. The compare-hit output is high for one bus clock after each tick on which the count equals C.
- R7: With the modulus enable at 1 and a compare value of 0x0000, the count stays at 0x0000.
- R8: With the modulus enable at 1 and a compare value of 0xFFFF, the return from 0xFFFF to 0x0000 does not set the overflow flag.
- R9: A free-running roll from 0xFFFF to 0x0000 sets the overflow flag. The flag stays set until a flag write with data bit 1. A flag write with data bit 0 has no effect.
- R10: The interrupt request is high exactly while the overflow flag is 1 and the overflow-interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data |
| cmp7_val | input | 16 | Channel-7 compare value |
| flg_we | input | 1 | Overflow flag write strobe |
| flg_wbit | input | 1 | Flag write data; 1 clears the flag |
| cnt_val | output | 16 | Live counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| cmp7_hit | output | 1 | One-cycle compare-match pulse |

## Verification
A wrong prescaler state shows up at the count as a change in step rate. A stuck `PS_PENDING` keeps the old rate indefinitely. A premature commit changes the rate within fewer than 128 bus clocks of the write. Measuring count deltas over windows that are multiples of 128 clocks catches both faults within a few hundred cycles. Errors in the counter or the flag logic appear at the roll over 0xFFFF: either the flag or the count is wrong within one bus clock of the wrap, which the bench reaches after about 65,536 cycles at ÷1.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int CNT_W    = 16;
    localparam int PR_W     = 3;
    localparam int CTL_W    = 8;
    localparam int BIT_TOI  = 7;
    localparam int BIT_TCRE = 3;

    typedef enum logic {
        PS_STEADY  = 1'b0,
        PS_PENDING = 1'b1
    } psc_state_e;
endpackage

// File: rtl/ptmr_presc.sv
module ptmr_presc
    import ptmr_pkg::*;
#(
    parameter int SEL_W = PR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_req,
    output logic             tick
);
    localparam int STG_W = (1 << SEL_W) - 1;

    psc_state_e         state_q, state_d;
    logic [SEL_W-1:0]   act_q, act_d;
    logic [STG_W-1:0]   stg_q;
    logic [STG_W-1:0]   stg_mask;
    logic               stg_zero;

    // Per-stage mask: stage i takes part in the divide when active select > i
    for (genvar i = 0; i < STG_W; i++) begin : g_mask
        assign stg_mask[i] = (32'(act_q) > i);
    end

    assign stg_zero = (stg_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q   <= '0;
            state_q <= PS_STEADY;
            act_q   <= '0;
        end else begin
            stg_q   <= stg_q + 1'b1;
            state_q <= state_d;
            act_q   <= act_d;
        end
    end

    always_comb begin
        state_d = state_q;
        act_d   = act_q;
        unique case (state_q)
            PS_STEADY: begin
                if (sel_req != act_q) state_d = PS_PENDING;   // request
            end
            PS_PENDING: begin
                if (stg_zero) begin                          // commit
                    act_d   = sel_req;
                    state_d = PS_STEADY;
                end
            end
            default: state_d = PS_STEADY;
        endcase
    end

    // Tick when all participating stages are at their top value
    always_comb begin
        tick = &(stg_q | ~stg_mask);
    end

    // R4: active ratio only changes right after an all-zero stage cycle
    a_r4_switch_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!stg_zero) |=> $stable(act_q));
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count
    import ptmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         mod_en,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt_q,
    output logic         hit_q,
    output logic         wrap_q
);
    logic match;
    logic at_top;
    logic mod_clear;

    assign match     = (cnt_q == cmp_val);
    assign at_top    = &cnt_q;
    assign mod_clear = mod_en && match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hit_q  <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            hit_q  <= tick && match;
            wrap_q <= tick && at_top && !mod_clear;
            if (tick) begin
                if (mod_clear) cnt_q <= '0;
                else           cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: count moves only on prescaled ticks
    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    // R7: zero compare in modulus mode pins the count at zero
    a_r7_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && cmp_val == '0 && cnt_q == '0) |=> (cnt_q == '0));

    // R8: modulus clear at all-ones gives no wrap event
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mod_en && at_top && match) |=> (!wrap_q && cnt_q == '0));
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic [CNT_W-1:0] cmp7_val,
    input  logic             flg_we,
    input  logic             flg_wbit,
    output logic [CNT_W-1:0] cnt_val,
    output logic             ovf_flag,
    output logic             irq,
    output logic             cmp7_hit
);
    logic            toi_q;
    logic            tcre_q;
    logic [PR_W-1:0] pr_q;
    logic            flag_q;
    logic            tick;
    logic            wrap;
    logic            clr_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            toi_q  <= 1'b0;
            tcre_q <= 1'b0;
            pr_q   <= '0;
        end else if (ctl_we) begin
            toi_q  <= ctl_wdata[BIT_TOI];
            tcre_q <= ctl_wdata[BIT_TCRE];
            pr_q   <= ctl_wdata[PR_W-1:0];
        end
    end

    ptmr_presc #(.SEL_W(PR_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_req (pr_q),
        .tick    (tick)
    );

    ptmr_count #(.W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mod_en  (tcre_q),
        .cmp_val (cmp7_val),
        .cnt_q   (cnt_val),
        .hit_q   (cmp7_hit),
        .wrap_q  (wrap)
    );

    assign clr_req = flg_we && flg_wbit;

    // Set wins over a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (wrap)    flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    always_comb begin
        ctl_rdata           = '0;
        ctl_rdata[BIT_TOI]  = toi_q;
        ctl_rdata[BIT_TCRE] = tcre_q;
        ctl_rdata[PR_W-1:0] = pr_q;
        ovf_flag            = flag_q;
        irq                 = flag_q && toi_q;
    end

    // R9: flag is sticky until a write-one clear
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);

    // R9: flag only rises after a counter wrap event
    a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !wrap) |=> !flag_q);
endmodule

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic [15:0] cmp7_val = '0;
    logic        flg_we = 1'b0;
    logic        flg_wbit = 1'b0;
    logic [15:0] cnt_val;
    logic        ovf_flag;
    logic        irq;
    logic        cmp7_hit;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ptmr_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .cmp7_val  (cmp7_val),
        .flg_we    (flg_we),
        .flg_wbit  (flg_wbit),
        .cnt_val   (cnt_val),
        .ovf_flag  (ovf_flag),
        .irq       (irq),
        .cmp7_hit  (cmp7_hit)
    );

    // Table: {prescale select, expected count delta over 256 bus clocks}
    localparam logic [15:0] VEC [4] = '{
        {3'd0, 13'd256},
        {3'd2, 13'd64},
        {3'd5, 13'd8},
        {3'd7, 13'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
        cyc(1);
        ctl_we = 1'b0;
    endtask

    task automatic wr_flg(input logic b);
        flg_we = 1'b1; flg_wbit = b;
        cyc(1);
        flg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] a;
        logic [15:0] b;
        int gap;
        cyc(3);
        // R1 reset state
        check("R1 cnt", cnt_val, 0);
        check("R1 ctl", ctl_rdata, 0);
        check("R1 flag/irq/hit", {ovf_flag, irq, cmp7_hit}, 0);
        rst_n = 1'b1;

        // R2 layout and reserved bits
        cmp7_val = 16'hF000;
        wr_ctl(8'hFF);
        check("R2 readback", ctl_rdata, 8'h8F);
        wr_ctl(8'h00);
        check("R2 clear", ctl_rdata, 8'h00);

        // R3 table of ratios
        for (int k = 0; k < 4; k++) begin
            wr_ctl({5'd0, VEC[k][15:13]});
            cyc(300);
            a = cnt_val;
            cyc(256);
            b = cnt_val;
            check("R3 delta", 32'(b - a), 32'(VEC[k][12:0]));
        end

        // R4 delayed switch: now at /128; align to a tick, then request /1
        a = cnt_val;
        while (cnt_val == a) cyc(1);
        a = cnt_val;
        wr_ctl(8'h00);
        cyc(99);
        check("R4 old ratio held", cnt_val, a);
        cyc(200);
        a = cnt_val;
        cyc(64);
        check("R4 new ratio", 32'(cnt_val - a), 64);

        // R6 modulus mode
        cmp7_val = 16'h2000;
        wr_ctl(8'h08);
        gap = 0;
        while (!cmp7_hit && gap < 9000) begin cyc(1); gap++; end
        check("R6 first hit seen", cmp7_hit, 1);
        check("R6 count cleared", cnt_val, 0);
        cmp7_val = 16'd10;
        cyc(1);
        check("R6 hit one cycle", cmp7_hit, 0);
        gap = 1;
        while (!cmp7_hit && gap < 100) begin cyc(1); gap++; end
        check("R6 period C+1", gap, 11);
        cyc(5);
        check("R6 count in range", cnt_val, 5);

        // R7 zero compare
        while (!cmp7_hit) cyc(1);
        cmp7_val = 16'h0000;
        cyc(50);
        check("R7 stays zero", cnt_val, 0);

        // R8 all-ones compare: no flag on modulus clear
        cmp7_val = 16'hFFFF;
        cyc(66000);
        check("R8 no flag", ovf_flag, 0);
        check("R8 wrapped", 32'(cnt_val < 16'd1000), 1);

        // R5 / R9 / R10 free-running wrap
        wr_ctl(8'h00);
        cyc(66000);
        check("R9 flag set", ovf_flag, 1);
        check("R5 count rolled", 32'(cnt_val < 16'd1000), 1);
        check("R10 irq masked", irq, 0);
        wr_ctl(8'h80);
        check("R10 irq asserted", irq, 1);
        wr_flg(1'b0);
        check("R9 write 0 ignored", ovf_flag, 1);
        wr_flg(1'b1);
        check("R9 w1c", ovf_flag, 0);
        check("R10 irq drops", irq, 0);

        finish_run();
    end
endmodule